// File: doc/BRIEF.md
# Multi-cycle shift and rotate unit

This execution unit shifts or rotates a byte, word or long operand by a count. The operation can be arithmetic shift, logical shift, plain rotate, or rotate through the extend flag, in either direction. It returns the result and the five condition flags: extend (X), negative (N), zero (Z), overflow (V) and carry (C). Completion follows a legacy timing model. In the register form the result appears after a base of 6 clocks (byte and word) or 8 clocks (long), plus two clocks for each bit of count. In the memory form the unit shifts one word by one bit, and the result always takes 8 clocks.

A request enters on a valid/ready handshake. `in_ready` is high only while the unit is idle, so one request is in flight at a time. The request is accepted on the clock edge where both `in_valid` and `in_ready` are high, and all request fields are sampled on that edge. The result is offered on `out_valid` and stays there, with stable data and flags, until `out_ready` is seen high. The unit accepts a new request only after that. Back-pressure on the output therefore stalls the input side.

The latency L is the number of rising edges from the accepting edge up to and including the edge after which `out_valid` first reads high.

Top module: `shift_rotate_unit`

## Requirements
- R1: `in_op` selects the operation. Bit 0 gives the direction (1 = left, 0 = right). Bits [2:1] give the kind: 00 arithmetic (a right shift replicates the sign bit), 01 logical (zero fill), 10 rotate through X (a ring of size+1 bits), 11 plain rotate.
- R2: `in_size` selects the operand size: 00 byte, 01 word, 10 long; 11 behaves as long. Bits of `out_data` above the operand size equal the corresponding bits of `in_data`.
- R3: When `in_imm` is 1, the count is `in_count[2:0]`, and the value 0 means 8; bits [5:3] are ignored. When `in_imm` is 0, the count is the full 6-bit `in_count` (0 to 63).
- R4: In the register form (`in_mem` = 0), L = 6 + 2n for byte and word and L = 8 + 2n for long, where n is the decoded count.
- R5: In the memory form (`in_mem` = 1), the operand is a word, the count is 1 regardless of `in_count`, `in_imm` and `in_size`, and L = 8.
- R6: C takes the last bit shifted or rotated out. X takes the same bit for every kind except plain rotate, which leaves X unchanged. For a zero count, X is unchanged and C is 0, except for rotate through X, where C equals the incoming X.
- R7: V is 1 only for an arithmetic left shift during which the most significant bit of the sized operand changed at any step. V is 0 for every other operation and for a zero count.
- R8: N equals the most significant bit of the sized result. Z is 1 exactly when the sized result is zero.
- R9: After reset, `in_ready` is 1 and `out_valid` is 0. `in_ready` is 0 from the accepting edge until the result handshake. `in_ready` and `out_valid` are never high together. While `out_valid` is 1 and `out_ready` is 0, the data and flags hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit idle and able to accept a request |
| in_op | input | 3 | Operation kind and direction |
| in_size | input | 2 | Operand size code |
| in_mem | input | 1 | 1 selects the memory form |
| in_imm | input | 1 | 1 selects the 3-bit immediate count |
| in_count | input | 6 | Shift count field |
| in_data | input | 32 | Operand |
| in_x | input | 1 | Incoming extend flag |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 32 | Result |
| out_x | output | 1 | Extend flag |
| out_n | output | 1 | Negative flag |
| out_z | output | 1 | Zero flag |
| out_v | output | 1 | Overflow flag |
| out_c | output | 1 | Carry flag |

## Verification
The checker assumes that the request fields matter only on the accepting edge, and it captures them there. It also assumes the sizes 00, 01 and 10 are the ones that occur, with 11 decoded like 10. Its latency and pass-through properties build on this.

The stimulus holds every request field steady from the negative edge where `in_valid` rises until the handshake edge, then drops `in_valid`. The stimulus never uses size code 11. It varies `out_ready` pseudo-randomly, so results wait under back-pressure, while `out_valid` and `out_ready` are otherwise left free.

// File: rtl/srot_pkg.sv
package srot_pkg;
  localparam int DW = 32;

  // op[2:1] kind, op[0] direction (1 = left)
  localparam logic [1:0] K_ARITH = 2'b00;
  localparam logic [1:0] K_LOGIC = 2'b01;
  localparam logic [1:0] K_RXTD  = 2'b10;
  localparam logic [1:0] K_ROT   = 2'b11;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_RSVD = 2'b11
  } srot_size_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_RUN  = 2'b01,
    PH_DONE = 2'b10
  } srot_phase_e;

  typedef struct packed {
    logic [DW-1:0] val;
    logic          x;
    logic          c;
    logic          v;
  } srot_state_t;

  function automatic int msb_of(srot_size_e s);
    case (s)
      SZ_BYTE: return 7;
      SZ_WORD: return 15;
      default: return DW - 1;
    endcase
  endfunction
endpackage

// File: rtl/srot_decode.sv
module srot_decode
  import srot_pkg::*;
#(
  parameter int CNT_W = 6,
  parameter int LAT_W = 8
) (
  input  logic             mem_form,
  input  logic             imm_form,
  input  logic [CNT_W-1:0] count,
  input  logic [1:0]       size_raw,
  output srot_size_e       eff_size,
  output logic [CNT_W-1:0] steps,
  output logic [LAT_W-1:0] latency
);
  localparam int BASE_SHORT = 6;
  localparam int BASE_LONG  = 8;
  localparam int MEM_LAT    = 8;

  logic [LAT_W-1:0] base;

  always_comb begin
    if (mem_form) begin
      eff_size = SZ_WORD;
      steps    = CNT_W'(1);
    end else begin
      eff_size = srot_size_e'(size_raw);
      if (imm_form)
        steps = (count[2:0] == 3'd0) ? CNT_W'(8) : CNT_W'(count[2:0]);
      else
        steps = count;
    end
    base = (eff_size == SZ_BYTE || eff_size == SZ_WORD) ? LAT_W'(BASE_SHORT)
                                                        : LAT_W'(BASE_LONG);
    if (mem_form) latency = LAT_W'(MEM_LAT);
    else          latency = base + (LAT_W'(steps) << 1);
  end
endmodule

// File: rtl/srot_step.sv
module srot_step
  import srot_pkg::*;
(
  input  srot_state_t cur,
  input  logic [2:0]  op,
  input  srot_size_e  size,
  output srot_state_t nxt
);
  logic [1:0] kind;
  logic       left;
  logic       top, bot, fill, out_bit;
  int         msb;

  always_comb begin
    kind = op[2:1];
    left = op[0];
    msb  = msb_of(size);
    nxt  = cur;
    top  = cur.val[msb];
    bot  = cur.val[0];
    if (left) begin
      out_bit = top;
      case (kind)
        K_RXTD:  fill = cur.x;
        K_ROT:   fill = top;
        default: fill = 1'b0;
      endcase
      for (int i = 1; i < DW; i++)
        if (i <= msb) nxt.val[i] = cur.val[i-1];
      nxt.val[0] = fill;
      if (kind == K_ARITH) nxt.v = cur.v | (top ^ cur.val[msb-1]);
    end else begin
      out_bit = bot;
      case (kind)
        K_RXTD:  fill = cur.x;
        K_ROT:   fill = bot;
        K_ARITH: fill = top;
        default: fill = 1'b0;
      endcase
      for (int i = 0; i < DW - 1; i++)
        if (i < msb) nxt.val[i] = cur.val[i+1];
      nxt.val[msb] = fill;
    end
    nxt.c = out_bit;
    if (kind != K_ROT) nxt.x = out_bit;
  end
endmodule

// File: rtl/srot_timer.sv
module srot_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         run,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                  cnt <= '0;
    else if (load)               cnt <= load_val;
    else if (run && cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
  import srot_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [2:0]    in_op,
  input  logic [1:0]    in_size,
  input  logic          in_mem,
  input  logic          in_imm,
  input  logic [CNT_W-1:0] in_count,
  input  logic [DW-1:0] in_data,
  input  logic          in_x,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          out_x,
  output logic          out_n,
  output logic          out_z,
  output logic          out_v,
  output logic          out_c
);
  localparam int MAX_LAT = 8 + 2 * ((1 << CNT_W) - 1);
  localparam int LAT_W   = $clog2(MAX_LAT + 1);

  srot_phase_e      phase;
  srot_state_t      cur, step_nxt;
  logic [2:0]       op_q;
  srot_size_e       size_q;
  logic [CNT_W-1:0] steps_q;

  srot_size_e       dec_size;
  logic [CNT_W-1:0] dec_steps;
  logic [LAT_W-1:0] dec_lat;
  logic             accept, tmr_expired;

  assign in_ready = (phase == PH_IDLE);
  assign accept   = in_valid && in_ready;

  srot_decode #(.CNT_W(CNT_W), .LAT_W(LAT_W)) u_dec (
    .mem_form (in_mem),
    .imm_form (in_imm),
    .count    (in_count),
    .size_raw (in_size),
    .eff_size (dec_size),
    .steps    (dec_steps),
    .latency  (dec_lat)
  );

  srot_step u_step (
    .cur  (cur),
    .op   (op_q),
    .size (size_q),
    .nxt  (step_nxt)
  );

  srot_timer #(.W(LAT_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_val (dec_lat - 1'b1),
    .run      (phase == PH_RUN),
    .expired  (tmr_expired)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      cur     <= '0;
      op_q    <= '0;
      size_q  <= SZ_BYTE;
      steps_q <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (in_valid) begin
          cur.val <= in_data;
          cur.x   <= in_x;
          cur.c   <= (in_op[2:1] == K_RXTD) ? in_x : 1'b0;
          cur.v   <= 1'b0;
          op_q    <= in_op;
          size_q  <= dec_size;
          steps_q <= dec_steps;
          phase   <= PH_RUN;
        end
        PH_RUN: begin
          if (steps_q != '0) begin
            cur     <= step_nxt;
            steps_q <= steps_q - 1'b1;
          end
          if (tmr_expired) phase <= PH_DONE;
        end
        PH_DONE: if (out_ready) phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  logic [DW-1:0] size_mask;
  always_comb begin
    case (size_q)
      SZ_BYTE: size_mask = DW'(32'h0000_00FF);
      SZ_WORD: size_mask = DW'(32'h0000_FFFF);
      default: size_mask = '1;
    endcase
  end

  assign out_valid = (phase == PH_DONE);
  assign out_data  = cur.val;
  assign out_x     = cur.x;
  assign out_c     = cur.c;
  assign out_v     = cur.v;
  assign out_n     = cur.val[msb_of(size_q)];
  assign out_z     = ((cur.val & size_mask) == '0);
endmodule

// File: rtl/srot_checker.sv
module srot_checker
  import srot_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [2:0]       in_op,
  input logic [1:0]       in_size,
  input logic             in_mem,
  input logic             in_imm,
  input logic [CNT_W-1:0] in_count,
  input logic [DW-1:0]    in_data,
  input logic             out_valid,
  input logic             out_ready,
  input logic [DW-1:0]    out_data,
  input logic             out_x,
  input logic             out_n,
  input logic             out_z,
  input logic             out_v,
  input logic             out_c
);
  localparam int SW = 10;

  logic [2:0]    cap_op;
  logic          cap_mem;
  logic [1:0]    cap_sz;
  logic [DW-1:0] cap_data;
  logic [SW-1:0] cap_lat, since;
  int            n_req, lat_req;

  always_comb begin
    if (in_imm) n_req = (in_count[2:0] == 3'd0) ? 8 : int'(in_count[2:0]);
    else        n_req = int'(in_count);
    if (in_mem) lat_req = 8;
    else        lat_req = ((in_size == 2'b00 || in_size == 2'b01) ? 6 : 8) + 2 * n_req;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_op <= '0; cap_mem <= 1'b0; cap_sz <= '0; cap_data <= '0;
      cap_lat <= '0; since <= '0;
    end else if (in_valid && in_ready) begin
      cap_op   <= in_op;
      cap_mem  <= in_mem;
      cap_sz   <= in_mem ? 2'b01 : in_size;
      cap_data <= in_data;
      cap_lat  <= SW'(lat_req);
      since    <= '0;
    end else if (!out_valid && since != '1) begin
      since <= since + 1'b1;
    end
  end

  assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) &&
      $stable({out_x, out_n, out_z, out_v, out_c}));

  assert_upper_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && cap_sz == 2'b00 |-> out_data[DW-1:8] == cap_data[DW-1:8]);

  assert_upper_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && cap_sz == 2'b01 |-> out_data[DW-1:16] == cap_data[DW-1:16]);

  assert_vclear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && cap_op != {K_ARITH, 1'b1} |-> !out_v);

  assert_memtime_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) && cap_mem |-> since == SW'(8));

  assert_regtime_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) && !cap_mem |-> since == cap_lat);
endmodule

bind shift_rotate_unit srot_checker #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/shift_rotate_unit_test.sv
`timescale 1ns/1ps
module shift_rotate_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_op = '0;
  logic [1:0]  in_size = '0;
  logic        in_mem = 1'b0;
  logic        in_imm = 1'b0;
  logic [5:0]  in_count = '0;
  logic [31:0] in_data = '0;
  logic        in_x = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_data;
  logic        out_x, out_n, out_z, out_v, out_c;

  always #5 clk = ~clk;

  shift_rotate_unit uut (.*);

  typedef struct {
    logic [31:0] d;
    logic        x, n, z, v, c;
    int          lat;
    int          acc;
    string       dtag;
    string       ttag;
  } item_t;

  item_t q[$];
  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  bit    done_all = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, got, exp);
    end
  endtask

  // independent reference: masked-integer formulation
  task automatic ref_model(input logic [2:0] op, input int w, input int n, input logic [31:0] din,
                           input logic xin, output item_t it);
    logic [31:0] m, v, hi;
    logic x, c, ov, outb, fill, msb0;
    m  = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1);
    hi = din & ~m;
    v  = din & m;
    x  = xin;
    c  = (op[2:1] == 2'b10) ? xin : 1'b0;
    ov = 1'b0;
    for (int k = 0; k < n; k++) begin
      msb0 = v[w-1];
      if (op[0]) begin
        outb = v[w-1];
        fill = (op[2:1] == 2'b10) ? x : (op[2:1] == 2'b11) ? outb : 1'b0;
        v = ((v << 1) & m) | {31'd0, fill};
        if (op[2:1] == 2'b00 && v[w-1] != msb0) ov = 1'b1;
      end else begin
        outb = v[0];
        fill = (op[2:1] == 2'b10) ? x : (op[2:1] == 2'b11) ? outb :
               (op[2:1] == 2'b00) ? msb0 : 1'b0;
        v = (v >> 1) | ({31'd0, fill} << (w - 1));
      end
      c = outb;
      if (op[2:1] != 2'b11) x = outb;
    end
    it.d = v | hi;
    it.x = x; it.c = c; it.v = ov;
    it.n = v[w-1];
    it.z = (v == 32'd0);
  endtask

  task automatic send(input logic [2:0] op, input logic [1:0] sz, input logic mem, input logic imm,
                      input logic [5:0] cnt, input logic [31:0] d, input logic x);
    item_t it;
    int w, n;
    w = mem ? 16 : (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
    n = mem ? 1 : imm ? ((cnt[2:0] == 3'd0) ? 8 : int'(cnt[2:0])) : int'(cnt);
    ref_model(op, w, n, d, x, it);
    it.lat  = mem ? 8 : ((w == 32) ? 8 : 6) + 2 * n;
    it.ttag = mem ? "R5" : "R4";
    it.dtag = mem ? "R5" : imm ? "R3" : (w < 32) ? "R2" : "R1";
    @(negedge clk);
    in_op = op; in_size = sz; in_mem = mem; in_imm = imm; in_count = cnt;
    in_data = d; in_x = x; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    it.acc = cyc + 1;
    q.push_back(it);
    @(negedge clk);
    in_valid = 1'b0;
    check("R9", "in_ready while busy", {31'd0, in_ready}, 32'd0);
  endtask

  // monitor / scoreboard
  initial begin
    bit seen = 0;
    int first = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (out_valid && !seen) begin seen = 1; first = cyc; end
        out_ready = ($urandom % 4) != 0;
        if (out_valid && out_ready) begin
          if (q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R9 unexpected result: actual=%h expected=none", out_data);
          end else begin
            item_t e;
            e = q.pop_front();
            check(e.dtag, "data", out_data, e.d);
            check("R6", "x,c", {30'd0, out_x, out_c}, {30'd0, e.x, e.c});
            check("R7", "v", {31'd0, out_v}, {31'd0, e.v});
            check("R8", "n,z", {30'd0, out_n, out_z}, {30'd0, e.n, e.z});
            check(e.ttag, "latency", 32'(first - e.acc), 32'(e.lat));
          end
          seen = 0;
        end
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    check("R9", "reset in_ready", {31'd0, in_ready}, 32'd1);
    check("R9", "reset out_valid", {31'd0, out_valid}, 32'd0);
    // register form: all kinds, sizes, counts 0..63 (R1 R2 R4 R6 R7 R8)
    for (int sz = 0; sz < 3; sz++)
      for (int op = 0; op < 8; op++)
        for (int n = 0; n < 64; n++)
          send(3'(op), 2'(sz), 1'b0, 1'b0, 6'(n), $urandom, 1'($urandom));
    // immediate counts with noise in upper bits (R3)
    for (int sz = 0; sz < 3; sz++)
      for (int op = 0; op < 8; op++)
        for (int f = 0; f < 8; f++)
          send(3'(op), 2'(sz), 1'b0, 1'b1, {3'($urandom), 3'(f)}, $urandom, 1'($urandom));
    // sign/overflow corners for arithmetic left (R7)
    send(3'b001, 2'b00, 1'b0, 1'b0, 6'd1, 32'h0000_0040, 1'b0);
    send(3'b001, 2'b01, 1'b0, 1'b0, 6'd3, 32'h1234_F000, 1'b1);
    send(3'b000, 2'b10, 1'b0, 1'b0, 6'd40, 32'h8000_0000, 1'b0);
    // memory form: size and count fields ignored (R5)
    for (int op = 0; op < 8; op++)
      for (int k = 0; k < 4; k++)
        send(3'(op), 2'(k % 3), 1'b1, 1'(k[0]), 6'($urandom), $urandom, 1'(k[1]));
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule